// File: doc/BRIEF.md
# Offset and Gain Calibration Sequencer

This block sits between a decimation filter and the output register of a converter. On request it runs a self-timed calibration: first the modulator inputs are shorted together and the settled filter output is averaged into an offset value. Then the positive input is tied to the reference and the negative input to ground, and a second average yields a gain correction factor. While idle, each filter result is passed on corrected: the stored offset is subtracted first, then the difference is scaled by the gain factor and clipped to the output range.

The cycle is driven entirely by filter strobes. A fixed number of strobes is discarded for settling before each averaging window of eight. A sequential divider then forms the gain factor. A final settling wait with the inputs back on the pins ends the cycle. A sync rising edge or standby abandons a running calibration and leaves the previous coefficients in place. The coefficients are bound to the input range (unipolar or bipolar) chosen when the cycle started. Outside that range they are not applied.

Top module: `cal_seq`

## Requirements
- R1: After reset, busy=0, mux_sel=2'b00, out_valid=0, and the block holds no coefficients, so every result passes through unchanged until a calibration completes.
- R2: When cal_start is high in a clock where the block is idle and standby is low, busy is 1 from the next cycle on, and the level of bipolar in that clock is latched as the calibration range.
- R3: In the offset phase mux_sel=2'b01 (inputs shorted). The first SETTLE strobes are discarded (SETTLE_UNI=16 unipolar, SETTLE_BI=24 bipolar). The next eight samples are summed, and the floor of sum/8 is the new offset. Samples are unsigned in unipolar mode and two's complement in bipolar mode.
- R4: In the gain phase mux_sel=2'b10 (positive input to reference). SETTLE strobes are discarded, then eight are averaged the same way. With span = average − new offset, the gain is min(floor(T·2^15/span), 65535) in 1.15 unsigned format. T is 65535 in unipolar mode and 32767 in bipolar mode. The gain is 65535 when span ≤ 0.
- R5: After the gain window, mux_sel returns to 2'b00. The divider takes DW+FRAC clocks. SETTLE further strobes are then discarded. Busy falls after the last of these, and only in that clock are the new offset, gain and range committed.
- R6: An idle result x becomes clip(floor((x − offset)·gain/2^15)). The clip range is [0, 65535] in unipolar mode and [−32768, 32767] in bipolar mode.
- R7: out_valid pulses one clock after a strobe taken while idle and with standby low. There is no out_valid while busy or in standby.
- R8: While busy, a rising edge on sync_in or a high standby returns the block to idle in the next cycle. The previously committed offset, gain and range are left unchanged.
- R9: The stored coefficients are applied only while the live bipolar input equals the committed range. Otherwise results pass through uncorrected.
- R10: With at most one strobe per 32 clocks, a calibration lasts fewer than 6720 clocks in unipolar mode and fewer than 9024 clocks in bipolar mode.
- R11: When an abort falls in the same clock as the final settling strobe, the abort wins and nothing is committed.
- R12: cal_start is ignored while busy, and also while standby is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cal_start | input | 1 | Calibration request |
| bipolar | input | 1 | Input range: 1 bipolar (two's complement), 0 unipolar (straight binary) |
| sync_in | input | 1 | Resynchronisation; a rising edge aborts calibration |
| standby | input | 1 | Power-down request; aborts calibration and mutes output |
| smp_valid | input | 1 | Filter result strobe |
| smp_data | input | DW | Filter result |
| mux_sel | output | 2 | 00 input pins, 01 inputs shorted, 10 reference across inputs |
| busy | output | 1 | Calibration in progress |
| out_valid | output | 1 | Corrected result strobe |
| out_data | output | DW | Corrected result |

## Verification
Two events can land on the same clock: an abort (sync edge or standby), and the final settling strobe that would commit the new coefficients. The bench arms a trigger that raises standby exactly on the strobe the reference model identifies as the last one of the post-settle wait. It then checks that busy drops and that a known input still produces the output seen before the attempt. The same before/after comparison judges aborts by sync edge mid-average and by standby during the divide.

// File: rtl/cal_pkg.sv
// Shared types for the calibration sequencer.
// Assumes nothing beyond SystemVerilog enum support.
package cal_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_OFFS = 3'd1,
        ST_GAIN = 3'd2,
        ST_DIV  = 3'd3,
        ST_POST = 3'd4
    } cal_state_t;

    localparam logic [1:0] MUX_PINS  = 2'b00;
    localparam logic [1:0] MUX_SHORT = 2'b01;
    localparam logic [1:0] MUX_REF   = 2'b10;
endpackage

// File: rtl/cal_acc.sv
// Eight-sample accumulator with an averaged view that includes the
// sample currently presented. Assumes the caller clears it before a window.
module cal_acc #(
    parameter int XW = 18
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 add,
    input  logic signed [XW-1:0] din,
    output logic signed [XW-1:0] avg_o
);
    localparam int SW = XW + 3;

    logic signed [SW-1:0] sum;
    logic signed [SW-1:0] tot;

    // Running total plus the present sample, divided by eight (floor).
    always_comb begin
        tot   = sum + {{(SW-XW){din[XW-1]}}, din};
        avg_o = tot[XW+2:3];
    end

    // Accumulate the window; clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)      sum <= '0;
        else if (clr)    sum <= '0;
        else if (add)    sum <= tot;
    end
endmodule

// File: rtl/cal_div.sv
// Restoring divider, one quotient bit per clock, result saturated to QOW bits.
// Assumes start is only pulsed while not running; divisor 0 yields all ones.
module cal_div #(
    parameter int NW  = 31,
    parameter int DVW = 17,
    parameter int QOW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [NW-1:0]  dividend,
    input  logic [DVW-1:0] divisor,
    output logic           done,
    output logic [QOW-1:0] quo_sat
);
    localparam int CW = $clog2(NW);

    logic           run;
    logic [CW-1:0]  cnt;
    logic [DVW-1:0] rem;
    logic [DVW-1:0] d;
    logic [NW-1:0]  n;
    logic [NW-1:0]  q;
    logic [DVW:0]   trial;
    logic [DVW:0]   diff;
    logic           ge;
    logic [NW-1:0]  q_nx;

    // One restoring step on dividend bit cnt.
    always_comb begin
        trial     = {rem, n[cnt]};
        ge        = trial >= {1'b0, d};
        diff      = trial - {1'b0, d};
        q_nx      = q;
        q_nx[cnt] = ge;
    end

    assign done    = run && (cnt == '0);
    assign quo_sat = (|q_nx[NW-1:QOW]) ? {QOW{1'b1}} : q_nx[QOW-1:0];

    // Iteration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
            rem <= '0;
            d   <= '0;
            n   <= '0;
            q   <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CW'(NW - 1);
            rem <= '0;
            d   <= divisor;
            n   <= dividend;
            q   <= '0;
        end else if (run) begin
            rem <= ge ? diff[DVW-1:0] : trial[DVW-1:0];
            q   <= q_nx;
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/cal_corr.sv
// Combinational correction: (x - offset) * gain / 2^FRAC, clipped to range.
// Assumes offset and gain come from committed registers; apply=0 bypasses.
module cal_corr #(
    parameter int DW   = 16,
    parameter int FRAC = 15
) (
    input  logic                 bip,
    input  logic                 apply,
    input  logic [DW-1:0]        raw,
    input  logic signed [DW+1:0] offs,
    input  logic [FRAC:0]        gain,
    output logic [DW-1:0]        res
);
    localparam int XW = DW + 2;
    localparam int PW = XW + FRAC + 2;
    localparam int RW = XW + 2;
    localparam logic signed [RW-1:0] U_HI = RW'((2**DW) - 1);
    localparam logic signed [RW-1:0] B_HI = RW'((2**(DW-1)) - 1);
    localparam logic signed [RW-1:0] B_LO = ~B_HI;

    logic signed [XW-1:0] x;
    logic signed [XW-1:0] diff;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] shf;
    logic signed [RW-1:0] val;

    // Extend, subtract, scale, then clip.
    always_comb begin
        x    = bip ? {{2{raw[DW-1]}}, raw} : {2'b00, raw};
        diff = x - offs;
        prod = PW'(diff) * $signed({1'b0, gain});
        shf  = prod >>> FRAC;
        val  = apply ? shf[RW-1:0] : {{2{x[XW-1]}}, x};
        if (bip) begin
            if (val > B_HI)      res = B_HI[DW-1:0];
            else if (val < B_LO) res = B_LO[DW-1:0];
            else                 res = val[DW-1:0];
        end else begin
            if (val > U_HI)      res = U_HI[DW-1:0];
            else if (val < 0)    res = '0;
            else                 res = val[DW-1:0];
        end
    end
endmodule

// File: rtl/cal_seq.sv
// Offset/gain calibration sequencer between decimation filter and output.
// Assumes one filter strobe per result; coefficients reset to zero and are
// applied only after a completed calibration in the matching input range.
module cal_seq
    import cal_pkg::*;
#(
    parameter int DW         = 16,
    parameter int FRAC       = 15,
    parameter int SETTLE_UNI = 16,
    parameter int SETTLE_BI  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cal_start,
    input  logic          bipolar,
    input  logic          sync_in,
    input  logic          standby,
    input  logic          smp_valid,
    input  logic [DW-1:0] smp_data,
    output logic [1:0]    mux_sel,
    output logic          busy,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    localparam int XW   = DW + 2;
    localparam int GW   = FRAC + 1;
    localparam int NW   = DW + FRAC;
    localparam int DVW  = DW + 1;
    localparam int SMAX = (SETTLE_BI > SETTLE_UNI) ? SETTLE_BI : SETTLE_UNI;
    localparam int KW   = $clog2(SMAX + 9);
    localparam logic [NW-1:0] N_UNI = {{DW{1'b1}}, {FRAC{1'b0}}};
    localparam logic [NW-1:0] N_BI  = {1'b0, {(DW-1){1'b1}}, {FRAC{1'b0}}};

    cal_state_t           st;
    logic [KW-1:0]        k;
    logic                 lmode;
    logic                 sync_q;
    logic signed [XW-1:0] off_t;
    logic [GW-1:0]        gain_t;
    logic signed [XW-1:0] off_r;
    logic [GW-1:0]        gain_r;
    logic                 cal_vld;
    logic                 cal_mode;

    logic                 rise;
    logic                 abort;
    logic [KW-1:0]        settle;
    logic                 win;
    logic                 last;
    logic                 in_avg;
    logic signed [XW-1:0] x_cal;
    logic signed [XW-1:0] avg;
    logic signed [XW-1:0] span;
    logic [DVW-1:0]       divisor;
    logic                 div_go;
    logic                 div_done;
    logic [GW-1:0]        div_q;
    logic [DW-1:0]        corr_res;
    logic                 take_out;

    // Control decode for the current cycle.
    always_comb begin
        rise     = sync_in & ~sync_q;
        abort    = (st != ST_IDLE) && (standby || rise);
        settle   = lmode ? KW'(SETTLE_BI) : KW'(SETTLE_UNI);
        win      = k >= settle;
        last     = k == (settle + KW'(7));
        in_avg   = (st == ST_OFFS) || (st == ST_GAIN);
        x_cal    = lmode ? {{2{smp_data[DW-1]}}, smp_data} : {2'b00, smp_data};
        span     = avg - off_t;
        divisor  = (span > 0) ? span[DVW-1:0] : '0;
        div_go   = (st == ST_GAIN) && smp_valid && last && !abort;
        take_out = (st == ST_IDLE) && smp_valid && !standby;
    end

    // Phase-to-mux mapping.
    always_comb begin
        unique case (st)
            ST_OFFS: mux_sel = MUX_SHORT;
            ST_GAIN: mux_sel = MUX_REF;
            default: mux_sel = MUX_PINS;
        endcase
    end

    assign busy = (st != ST_IDLE);

    cal_acc #(.XW(XW)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((st == ST_IDLE) || abort || (in_avg && smp_valid && last)),
        .add   (in_avg && smp_valid && win),
        .din   (x_cal),
        .avg_o (avg)
    );

    cal_div #(.NW(NW), .DVW(DVW), .QOW(GW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_go),
        .dividend (lmode ? N_BI : N_UNI),
        .divisor  (divisor),
        .done     (div_done),
        .quo_sat  (div_q)
    );

    cal_corr #(.DW(DW), .FRAC(FRAC)) u_corr (
        .bip   (bipolar),
        .apply (cal_vld && (cal_mode == bipolar)),
        .raw   (smp_data),
        .offs  (off_r),
        .gain  (gain_r),
        .res   (corr_res)
    );

    // Output register: corrected results only while idle and awake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= take_out;
            if (take_out) out_data <= corr_res;
        end
    end

    // Calibration sequence and coefficient commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            k        <= '0;
            lmode    <= 1'b0;
            sync_q   <= 1'b0;
            off_t    <= '0;
            gain_t   <= '0;
            off_r    <= '0;
            gain_r   <= '0;
            cal_vld  <= 1'b0;
            cal_mode <= 1'b0;
        end else begin
            sync_q <= sync_in;
            if (abort) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: if (cal_start && !standby) begin
                        st    <= ST_OFFS;
                        k     <= '0;
                        lmode <= bipolar;
                    end
                    ST_OFFS: if (smp_valid) begin
                        if (last) begin
                            off_t <= avg;
                            k     <= '0;
                            st    <= ST_GAIN;
                        end else begin
                            k <= k + 1'b1;
                        end
                    end
                    ST_GAIN: if (smp_valid) begin
                        if (last) st <= ST_DIV;
                        else      k  <= k + 1'b1;
                    end
                    ST_DIV: if (div_done) begin
                        gain_t <= div_q;
                        k      <= '0;
                        st     <= ST_POST;
                    end
                    ST_POST: if (smp_valid) begin
                        if (k == settle - 1'b1) begin
                            off_r    <= off_t;
                            gain_r   <= gain_t;
                            cal_mode <= lmode;
                            cal_vld  <= 1'b1;
                            st       <= ST_IDLE;
                        end else begin
                            k <= k + 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cal_seq_chk.sv
// Port-level protocol checks for cal_seq, attached by bind below.
// Assumes strobes no denser than the bench and at most one per 32 clocks.
module cal_seq_chk #(
    parameter int LIM_UNI = 6720,
    parameter int LIM_BI  = 9024
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cal_start,
    input logic       bipolar,
    input logic       sync_in,
    input logic       standby,
    input logic       smp_valid,
    input logic [1:0] mux_sel,
    input logic       busy,
    input logic       out_valid
);
    logic [15:0] bcnt;
    logic        lm;

    // Busy-length counter and range seen at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
            lm   <= 1'b0;
        end else begin
            if (!busy) begin
                bcnt <= '0;
                lm   <= bipolar;
            end else if (bcnt != 16'hFFFF) begin
                bcnt <= bcnt + 1'b1;
            end
        end
    end

    assert_mux_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mux_sel != 2'b11);
    assert_mux_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mux_sel == 2'b00);
    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cal_start && !standby) |=> busy);
    assert_quiet_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !out_valid);
    assert_quiet_stby_R7: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !out_valid);
    assert_out_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(smp_valid));
    assert_abort_stby_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && standby) |=> !busy);
    assert_abort_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sync_in && !$past(sync_in)) |=> !busy);
    assert_no_start_stby_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && standby) |=> !busy);
    assert_time_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(bcnt) < (lm ? LIM_BI : LIM_UNI)));
endmodule

bind cal_seq cal_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cal_start (cal_start),
    .bipolar   (bipolar),
    .sync_in   (sync_in),
    .standby   (standby),
    .smp_valid (smp_valid),
    .mux_sel   (mux_sel),
    .busy      (busy),
    .out_valid (out_valid)
);

// File: tb/sim_cal_seq.sv
`timescale 1ns/1ps
module sim_cal_seq;
    localparam int SU = 16;
    localparam int SB = 24;
    localparam int NW = 31;
    localparam int SP = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_start = 1'b0;
    logic        bipolar = 1'b0;
    logic        sync_in = 1'b0;
    logic        standby = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic [1:0]  mux_sel;
    logic        busy;
    logic        out_valid;
    logic [15:0] out_data;

    cal_seq #(.DW(16), .FRAC(15), .SETTLE_UNI(SU), .SETTLE_BI(SB)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_start(cal_start), .bipolar(bipolar),
        .sync_in(sync_in), .standby(standby), .smp_valid(smp_valid),
        .smp_data(smp_data), .mux_sel(mux_sel), .busy(busy),
        .out_valid(out_valid), .out_data(out_data));

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // ---------------- analog stand-in values ----------------
    longint in_code = 0;
    longint off_code = 0;
    longint ref_code = 0;
    int     gcnt = 0;
    int     nidx = 0;
    bit     arm11 = 0;
    bit     hit11 = 0;
    bit     hold11 = 0;

    function automatic longint noise(input int i);
        case (i % 8)
            0: return 3;  1: return -1; 2: return 2;  3: return -4;
            4: return 0;  5: return 1;  6: return -2; default: return 1;
        endcase
    endfunction

    // ---------------- reference model ----------------
    int     m_ph = 0;
    int     m_k = 0;
    int     m_dc = 0;
    int     m_set = 0;
    bit     m_lm = 0;
    bit     m_sq = 0;
    bit     m_vld = 0;
    bit     m_mode = 0;
    longint m_sum = 0;
    longint m_offt = 0;
    longint m_gaint = 0;
    longint m_off = 0;
    longint m_gain = 0;
    bit     e_ov = 0;
    longint e_od = 0;

    function automatic longint ext(input logic [15:0] v, input bit bm);
        return bm ? longint'($signed(v)) : longint'(v);
    endfunction

    function automatic longint corr(input logic [15:0] r, input bit bm);
        longint x, v;
        x = ext(r, bm);
        if (m_vld && m_mode == bm) v = ((x - m_off) * m_gain) >>> 15;
        else v = x;
        if (bm) begin
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
        end else begin
            if (v > 65535) v = 65535;
            if (v < 0) v = 0;
        end
        return v;
    endfunction

    always @(posedge clk) begin
        bit rise;
        longint avg, span, g, nn;
        if (!rst_n) begin
            m_ph = 0; m_k = 0; m_sq = 0; m_vld = 0; m_mode = 0;
            m_off = 0; m_gain = 0; m_sum = 0; e_ov = 0; e_od = 0;
        end else begin
            rise = sync_in && !m_sq;
            m_sq = sync_in;
            if (m_ph == 0 && smp_valid && !standby) begin
                e_ov = 1; e_od = corr(smp_data, bipolar);
            end else e_ov = 0;
            m_set = m_lm ? SB : SU;
            if (m_ph != 0 && (standby || rise)) m_ph = 0;
            else case (m_ph)
                0: if (cal_start && !standby) begin
                    m_ph = 1; m_k = 0; m_lm = bipolar; m_sum = 0;
                end
                1, 2: if (smp_valid) begin
                    if (m_k >= m_set) m_sum += ext(smp_data, m_lm);
                    if (m_k == m_set + 7) begin
                        avg = m_sum >>> 3; m_sum = 0; m_k = 0;
                        if (m_ph == 1) begin
                            m_offt = avg; m_ph = 2;
                        end else begin
                            span = avg - m_offt;
                            nn = (m_lm ? 64'd32767 : 64'd65535) << 15;
                            if (span <= 0) g = 65535;
                            else begin
                                g = nn / span;
                                if (g > 65535) g = 65535;
                            end
                            m_gaint = g; m_dc = NW; m_ph = 3;
                        end
                    end else m_k++;
                end
                3: begin
                    m_dc--;
                    if (m_dc == 0) begin m_ph = 4; m_k = 0; end
                end
                default: if (smp_valid) begin
                    if (m_k == m_set - 1) begin
                        m_off = m_offt; m_gain = m_gaint; m_mode = m_lm;
                        m_vld = 1; m_ph = 0;
                    end else m_k++;
                end
            endcase
        end
    end

    // ---------------- stimulus generator and per-clock comparison ----------------
    always @(negedge clk) begin
        longint v;
        cycles++;
        if (rst_n) begin
            chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
            chk(mux_sel == (m_ph == 1 ? 2'b01 : (m_ph == 2 ? 2'b10 : 2'b00)),
                m_ph == 1 ? "R3 mux" : (m_ph == 2 ? "R4 mux" : "R5 mux"),
                mux_sel, m_ph == 1 ? 1 : (m_ph == 2 ? 2 : 0));
            chk(out_valid == e_ov, "R7 out_valid", out_valid, e_ov);
            if (e_ov) chk(out_data == e_od[15:0], "R6 out_data", out_data, e_od[15:0]);
        end
        if (hold11) begin standby = 0; hold11 = 0; end
        gcnt++;
        if (gcnt % SP == 0) begin
            case (mux_sel)
                2'b01:   v = off_code + noise(nidx);
                2'b10:   v = ref_code + noise(nidx);
                default: v = in_code;
            endcase
            nidx++;
            smp_valid = 1; smp_data = v[15:0];
            if (arm11 && m_ph == 4 && m_k == (m_lm ? SB : SU) - 1) begin
                standby = 1; arm11 = 0; hit11 = 1; hold11 = 1;
            end
        end else smp_valid = 0;
        if (cycles > 150000) begin
            chk(0, "watchdog", cycles, 150000);
            finish_run();
        end
    end

    task automatic get_out(input longint x, output logic [15:0] r);
        int got = 0;
        in_code = x;
        while (got < 2) begin
            @(negedge clk);
            if (out_valid) got++;
        end
        r = out_data;
    endtask

    task automatic run_cal(input bit bm, input longint oc, input longint rc, output int len);
        bipolar = bm; off_code = oc; ref_code = rc;
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        len = 0;
        while (busy) begin @(negedge clk); len++; end
    endtask

    initial begin
        logic [15:0] r, v1;
        int len;
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state and pass-through
        chk(!busy, "R1 busy", busy, 0);
        chk(mux_sel == 2'b00, "R1 mux", mux_sel, 0);
        get_out(12345, r);
        chk(r == 12345, "R1 passthrough", r, 12345);

        // R3 R4 R5 R10: unipolar calibration, R12: start while busy ignored
        bipolar = 0; off_code = 120; ref_code = 60000;
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        repeat (30) @(negedge clk);
        cal_start = 1; @(negedge clk); cal_start = 0;
        chk(busy == 1, "R12 start while busy", busy, 1);
        len = 32;
        while (busy) begin @(negedge clk); len++; end
        chk(len < 6720, "R10 unipolar length", len, 6720);

        // R6: corrected output and upper clip
        get_out(30000, v1);
        chk(v1 == corr(16'd30000, 0)[15:0], "R6 corrected", v1, corr(16'd30000, 0));
        get_out(65500, r);
        chk(r == 16'hFFFF, "R6 clip high", r, 65535);

        // R9: other range leaves data uncorrected
        bipolar = 1;
        get_out(16'h1234, r);
        chk(r == 16'h1234, "R9 mode mismatch", r, 16'h1234);
        bipolar = 0;

        // R8: sync abort mid-average keeps coefficients
        off_code = 500; ref_code = 50000;
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        repeat (40) @(negedge clk);
        sync_in = 1; @(negedge clk);
        chk(!busy, "R8 sync abort", busy, 0);
        sync_in = 0;
        get_out(30000, r);
        chk(r == v1, "R8 kept after sync", r, v1);

        // R8: standby abort during divide
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        while (!(busy && mux_sel == 2'b00)) @(negedge clk);
        standby = 1; @(negedge clk);
        chk(!busy, "R8 standby abort", busy, 0);
        standby = 0;
        get_out(30000, r);
        chk(r == v1, "R8 kept after standby", r, v1);

        // R12: start during standby ignored
        standby = 1; cal_start = 1; @(negedge clk);
        cal_start = 0; @(negedge clk);
        chk(!busy, "R12 start in standby", busy, 0);
        standby = 0;

        // R11: abort on the committing strobe
        arm11 = 1;
        @(negedge clk); cal_start = 1;
        @(negedge clk); cal_start = 0;
        while (busy) @(negedge clk);
        chk(hit11, "R11 collision reached", hit11, 1);
        get_out(30000, r);
        chk(r == v1, "R11 abort wins", r, v1);

        // bipolar calibration, R10 and R6 low clip
        run_cal(1, -50, 30000, len);
        chk(len < 9024, "R10 bipolar length", len, 9024);
        get_out(16'h8000, r);
        chk(r == 16'h8000, "R6 clip low", r, 16'h8000);
        get_out(1000, r);
        chk(r == corr(16'd1000, 1)[15:0], "R6 bipolar corrected", r, corr(16'd1000, 1));

        // R4: non-positive span saturates the gain
        run_cal(1, -50, -100, len);
        get_out(100, r);
        chk(r == 299, "R4 gain saturation", r, 299);

        finish_run();
    end
endmodule